// File: doc/BRIEF.md
# Signed Carry-Save Array Multiplier

This block multiplies two two's complement operands and returns their full-width two's complement product in the same cycle. It uses no clock or state. The core is a rectangular grid of AND gates and full-adder cells. Each operand bit pair forms one partial-product bit. One row of cells per multiplier bit adds the partial products in carry-save form. A final ripple row resolves the remaining sum and carry vectors.

Signed operands are handled inside the array and need no correction step. A partial-product bit that involves exactly one operand's sign bit has negative weight. Every wire in the array has a fixed polarity, positive or negative. Each adder cell is one of four variants, chosen by how many of its inputs are negative. The variant fixes the polarity of its sum and carry outputs, so the weighted value is preserved. The polarity of each position is set when the design is elaborated, from the operand width alone.

Top module: `sgn_array_mul`

## Requirements
- R1: For every pair of `W`-bit two's complement operands, `p_o` read as a `2W`-bit two's complement number equals the product of `a_i` and `b_i`.
- R2: The operand width `W` is a parameter (at least 3, default 5), and `p_o` is exactly `2W` bits wide.
- R3: A partial-product bit formed from exactly one operand's sign bit (bit `W-1`) is subtracted. For example, with W=5, -16 times 1, 1 times -16 and -16 times 3 give -16, -16 and -48.
- R4: The partial-product bit formed from both sign bits counts with positive weight. With W=5, -16 times -16 gives +256, which is `p_o` = 10'h100.
- R5: Each adder cell preserves the weighted value. Its inputs are taken as +1 or -1 times their bit according to their polarity. The sum output counts as +1 or -1 and the carry output as +2 or -2 times its bit. Mixed-sign operands such as -1 times -1, -5 times 7 and -8 times -3 therefore give 1, -35 and 24.
- R6: If either operand is zero, `p_o` is all zeros.
- R7: For a nonzero product, bit `2W-1` of `p_o` is the XOR of the two operands' bit `W-1`.
- R8: `p_o` depends only on the current operands, with no clock or stored state. A change of operands between clock edges shows on `p_o` before the next edge.
- R9: The extreme operands give 15 times 15 = 225, 15 times -16 = -240 and -16 times 15 = -240 for W=5, with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Multiplicand, two's complement |
| b_i | input | W | Multiplier, two's complement |
| p_o | output | 2W | Product, two's complement |

## Verification
The bench runs through every operand pair. This exposes any single misweighted cell, because each cell position is exercised with both values of all its inputs. The zero-operand pairs are separated from the rest to show that no constant offset is left from a missing correction. The corner pairs use the most negative value on either side, on both sides, and against the largest positive value. These tell a sign-bit product bit with the wrong sign apart from a wrong polarity in the top column. A mid-cycle operand change shows that the result does not wait for a clock edge.

// File: rtl/sgn_mul_pkg.sv
package sgn_mul_pkg;

  // polarity (1 = negative weight) of partial product a[i]*b[j]
  function automatic bit pp_neg(int w, int i, int j);
    return (i == w - 1) ^ (j == w - 1);
  endfunction

  // polarity of sum output of cell i in row j
  function automatic bit sum_neg(int w, int j, int i);
    if (j == 0) return (i == w - 1);
    if (j == w - 1) return 1'b0;
    return (i + j) >= (w - 1);
  endfunction

  // polarity of carry output of cell i in row j (j >= 1)
  function automatic bit car_neg(int w, int j, int i);
    if (j == w - 1) return 1'b1;
    return (i == w - 1);
  endfunction

  function automatic int neg_count(logic [2:0] m);
    return int'(m[0]) + int'(m[1]) + int'(m[2]);
  endfunction

endpackage

// File: rtl/pp_and_grid.sv
module pp_and_grid #(
  parameter int W = 5
) (
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  output logic [W-1:0][W-1:0]  pp_o
);

  for (genvar j = 0; j < W; j++) begin : g_row
    for (genvar i = 0; i < W; i++) begin : g_col
      assign pp_o[j][i] = a_i[i] & b_i[j];
    end
  end

endmodule

// File: rtl/wt_fa_cell.sv
module wt_fa_cell #(
  parameter logic [2:0] NEG = 3'b000
) (
  input  logic [2:0] x_i,
  output logic       s_o,
  output logic       c_o
);
  import sgn_mul_pkg::*;

  localparam int         NN    = neg_count(NEG);
  // one negative: flip it; two negatives: flip the positive one
  localparam logic [2:0] INV   = (NN == 1) ? NEG : ((NN == 2) ? ~NEG : 3'b000);
  localparam logic       SFLIP = (NN == 1) || (NN == 2);
  localparam bit         S_NEG = (NN == 1) || (NN == 3);
  localparam bit         C_NEG = (NN >= 2);

  logic [2:0] y;
  assign y   = x_i ^ INV;
  assign s_o = (^y) ^ SFLIP;
  assign c_o = (y[0] & y[1]) | (y[0] & y[2]) | (y[1] & y[2]);

  int w_in, w_out;
  always_comb begin
    w_in = 0;
    for (int k = 0; k < 3; k++) begin
      w_in += NEG[k] ? -int'(x_i[k]) : int'(x_i[k]);
    end
    w_out = (C_NEG ? -2 : 2) * int'(c_o) + (S_NEG ? -1 : 1) * int'(s_o);
  end

  always_comb begin
    p_cell_weight_r5: assert (w_in == w_out)
      else $error("cell weight mismatch: in %0d out %0d", w_in, w_out);
  end

endmodule

// File: rtl/ripple_row.sv
module ripple_row #(
  parameter int W = 5
) (
  input  logic [W-2:0] sum_i,  // positive weight, columns W..2W-2
  input  logic [W-1:0] car_i,  // negative weight, columns W..2W-1
  output logic [W-1:0] res_o   // product bits W..2W-1
);

  logic [W-1:0] rc;  // negative-weight ripple carries
  assign rc[0] = 1'b0;

  for (genvar k = 0; k < W - 1; k++) begin : g_bit
    wt_fa_cell #(.NEG(3'b110)) u_cell (
      .x_i ({rc[k], car_i[k], sum_i[k]}),
      .s_o (res_o[k]),
      .c_o (rc[k+1])
    );
  end

  // top column holds two negative bits; modulo 2^(2W) only their parity matters
  assign res_o[W-1] = car_i[W-1] ^ rc[W-1];

  always_comb begin
    p_top_single_r1: assert (!(car_i[W-1] && rc[W-1]))
      else $error("both negative bits set in top column");
  end

endmodule

// File: rtl/sgn_array_mul.sv
module sgn_array_mul #(
  parameter int W = 5
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  import sgn_mul_pkg::*;

  localparam int PW = 2 * W;

  logic [W-1:0][W-1:0] pp;
  logic [W-1:0][W-1:0] s_r;  // row sums, row j cell i at column i+j
  logic [W-1:1][W-1:0] c_r;  // row carries, into column i+j+1

  pp_and_grid #(.W(W)) u_pp (
    .a_i  (a_i),
    .b_i  (b_i),
    .pp_o (pp)
  );

  assign s_r[0] = pp[0];

  for (genvar j = 1; j < W; j++) begin : g_row
    for (genvar i = 0; i < W; i++) begin : g_cell
      localparam bit NP = pp_neg(W, i, j);
      localparam bit NS = (i == W - 1) ? 1'b1 : sum_neg(W, j - 1, i + 1);
      localparam bit NC = (j == 1) ? NP : car_neg(W, j - 1, i);
      logic sin, cin;
      if (i == W - 1) begin : g_edge
        assign sin = 1'b0;
      end else begin : g_inner
        assign sin = s_r[j-1][i+1];
      end
      if (j == 1) begin : g_first
        assign cin = 1'b0;
      end else begin : g_next
        assign cin = c_r[j-1][i];
      end
      wt_fa_cell #(.NEG({NC, NS, NP})) u_cell (
        .x_i ({cin, sin, pp[j][i]}),
        .s_o (s_r[j][i]),
        .c_o (c_r[j][i])
      );
    end
  end

  for (genvar j = 0; j < W; j++) begin : g_low
    assign p_o[j] = s_r[j][0];
  end

  ripple_row #(.W(W)) u_cpa (
    .sum_i (s_r[W-1][W-1:1]),
    .car_i (c_r[W-1]),
    .res_o (p_o[PW-1:W])
  );

  logic signed [PW-1:0] ref_p;
  assign ref_p = PW'($signed(a_i)) * PW'($signed(b_i));

  always_comb begin
    p_product_r1: assert ($signed(p_o) == ref_p)
      else $error("product mismatch");
    p_zero_r6: assert (!((a_i == '0) || (b_i == '0)) || (p_o == '0))
      else $error("zero operand gave nonzero product");
    p_sign_r7: assert ((p_o == '0) || (p_o[PW-1] == (a_i[W-1] ^ b_i[W-1])))
      else $error("product sign wrong");
    p_min_sq_r4: assert (!((a_i == {1'b1, {(W-1){1'b0}}}) && (b_i == {1'b1, {(W-1){1'b0}}}))
                         || (p_o == {2'b01, {(PW-2){1'b0}}}))
      else $error("min times min wrong");
  end

endmodule

// File: tb/test_sgn_array_mul.sv
module test_sgn_array_mul;
  localparam int W  = 5;
  localparam int PW = 2 * W;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1));

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4ns clk = ~clk;

  logic [W-1:0]  a, b;
  logic [PW-1:0] p;
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  sgn_array_mul #(.W(W)) i_sgn_array_mul (
    .a_i (a),
    .b_i (b),
    .p_o (p)
  );

  task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d actual=%h expected=%h", req,
               $signed(a), $signed(b), act, exp);
    end
  endtask

  // drive after an edge, check mid-cycle against the queued reference
  task automatic apply(int x, int y, string req);
    int e;
    @(posedge clk);
    a = x[W-1:0];
    b = y[W-1:0];
    exp_q.push_back(x * y);
    #3ns;
    e = exp_q.pop_front();
    check(req, p, e[PW-1:0]);
    if (e != 0) check("R7", {9'b0, p[PW-1]}, {9'b0, (e < 0)});
  endtask

  initial begin
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    #2ns;
    check("R6", p, '0);  // idle state under reset
    rst_ni = 1'b1;

    check("R2", PW'($bits(p)), PW'(2 * W));

    for (int ia = LO; ia < HI; ia++) begin
      for (int ib = LO; ib < HI; ib++) begin
        apply(ia, ib, (ia == 0 || ib == 0) ? "R6" : "R1");
      end
    end

    apply(LO, 1, "R3");
    apply(1, LO, "R3");
    apply(LO, 3, "R3");
    apply(LO, LO, "R4");
    apply(-1, -1, "R5");
    apply(-5, 7, "R5");
    apply(-8, -3, "R5");
    apply(HI - 1, HI - 1, "R9");
    apply(HI - 1, LO, "R9");
    apply(LO, HI - 1, "R9");

    // R8: operands change between edges, result visible before next edge
    @(posedge clk);
    #1ns;
    a = 5'd3;
    b = 5'b11110;
    #1ns;
    check("R8", p, 10'h3fa);
    a = 5'b11001;
    #1ns;
    check("R8", p, 10'h00e);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule